// File: doc/BRIEF.md
# Edge-Triggered Capture Buffer

This block takes a snapshot of a wide parallel input, built from several byte-wide ports, and holds it until a talker-side consumer asks for it. A snapshot is taken either on request (direct mode), or whenever the level on a selected data-ready line changes in either direction (capture modes). One capture mode keeps a single reading. The other keeps a first-in, first-out queue of up to `DEPTH` readings. When a new reading arrives and there is no room for it, the reading is discarded and a sticky overrun flag is raised.

A consumer pulses `talk_req` to get one reading. It gets it on `rd_valid`/`rd_data` and passes it on to a downstream byte serialiser. If a capture mode has nothing stored, the request waits for the next capture. In direct mode the block raises `inhibit` around the port sample so that external hardware can hold its outputs steady. A separate `status_req` pulse returns the overrun flag and clears it, without touching the stored readings or the read path.

Top module: `cap_edge_buffer`

## Requirements
- R1: After synchronous reset, `inhibit`, `rd_valid`, `status_valid`, `status_err` and `overrun` are 0, and nothing is stored.
- R2: Mode code 0 (and the unused code 3) is direct mode. A `talk_req` seen at clock edge k raises `inhibit` for exactly INH_HOLD cycles after edge k. `port_in` is sampled at edge k+INH_HOLD, where `inhibit` falls, and `rd_valid` is high for that one cycle with the sample. A `talk_req` seen while `inhibit` is high is ignored.
- R3: Only the data-ready line picked by `chan_sel` causes captures, and a rise and a fall both count. Each line passes through two synchroniser flops. A level change on the line before edge e0 makes the capture sample `port_in` at edge e0+2.
- R4: Mode code 1 keeps one reading. A `talk_req` while it is held puts that reading on `rd_data` with `rd_valid` in the cycle after the request edge, and empties the slot.
- R5: In mode 1, a data-ready change while a reading is held and not being read in that cycle drops the new reading, sets `overrun`, and leaves the held reading unchanged.
- R6: Mode code 2 queues readings and returns them in arrival order. It holds up to DEPTH (2000) of them, and its pointers wrap around.
- R7: In mode 2, a capture with DEPTH unread readings stored (and none read in that cycle) is dropped and sets `overrun`.
- R8: In modes 1 and 2, a `talk_req` with nothing stored waits. The first later capture is returned one cycle after it is stored. Each request returns exactly one reading.
- R9: A `status_req` at edge s gives `status_valid`=1 and `status_err` = the overrun flag before edge s, in the next cycle. It clears `overrun` unless a new overrun happens at that same edge. It does not change `inhibit`, the stored readings or a waiting request.
- R10: `overrun` stays set until a `status_req` clears it.
- R11: A change of `mode_sel` empties both stores, cancels a waiting request and any direct read in progress. Data-ready changes in direct mode store nothing.
- R12: `inhibit` is never high while modes 1 or 2 are in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 0/3 direct, 1 single hold, 2 queue |
| chan_sel | input | CH_W (1) | Selects the data-ready line that captures |
| rdy_in | input | NUM_CH (2) | Asynchronous data-ready lines |
| port_in | input | NUM_PORTS*PORT_W (40) | Port p occupies bits [8p+7:8p] |
| talk_req | input | 1 | Request one reading |
| status_req | input | 1 | Request the overrun status and clear it |
| inhibit | output | 1 | High while a direct read samples the ports |
| rd_valid | output | 1 | One-cycle strobe for a reading |
| rd_data | output | NUM_PORTS*PORT_W (40) | Reading |
| status_valid | output | 1 | One-cycle strobe for a status reply |
| status_err | output | 1 | Overrun flag as reported |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A capture lands in storage three falling edges after the data-ready toggle: two synchroniser flops, then the write. A waiting request is answered one cycle later. So the bench drives on falling edges and tests `rd_valid` at exactly the fourth falling edge, and also tests that it is low at each edge before that. A direct read is checked edge by edge: `inhibit` must be high at the first and second falling edges after the request and low at the third, where `rd_data` must hold the port value driven just before that edge and not the earlier one. Overrun and status replies are sampled one cycle after the edge that causes them. The queue is filled to exactly 2000 and then pushed once more, and every reading is compared with a value computed arithmetically from its index.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        CM_DIRECT = 2'd0,
        CM_SINGLE = 2'd1,
        CM_DEEP   = 2'd2
    } cap_mode_e;

    // Read-side control decided each cycle
    typedef struct packed {
        logic serve;    // pop a stored reading onto the output
        logic pend_nx;  // request still waiting after this edge
        logic start;    // begin a direct port read
    } rd_ctl_t;

    function automatic cap_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd1:    return CM_SINGLE;
            2'd2:    return CM_DEEP;
            default: return CM_DIRECT;
        endcase
    endfunction

    function automatic logic sticky_next(input logic cur, input logic clr, input logic set);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
    parameter int NUM_CH = 2,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] rdy_in,
    input  logic [CH_W-1:0]   chan_sel,
    output logic              edge_o
);

    logic [NUM_CH-1:0] sync_a;
    logic [NUM_CH-1:0] sync_b;
    logic [NUM_CH-1:0] last_lvl;
    logic [NUM_CH-1:0] changed;

    // Each line keeps its own history, so switching the selection never fakes an edge
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_a[c]   <= 1'b0;
                    sync_b[c]   <= 1'b0;
                    last_lvl[c] <= 1'b0;
                end else begin
                    sync_a[c]   <= rdy_in[c];
                    sync_b[c]   <= sync_a[c];
                    last_lvl[c] <= sync_b[c];
                end
            end
            assign changed[c] = sync_b[c] ^ last_lvl[c];
        end
    endgenerate

    assign edge_o = changed[chan_sel];

endmodule

// File: rtl/cap_hold.sv
module cap_hold #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic         full,
    output logic [W-1:0] rd_data,
    output logic         ovr
);

    logic         full_q;
    logic [W-1:0] data_q;
    logic         accept;

    // A read in the same cycle frees the slot for the incoming reading
    assign accept  = wr_en & (~full_q | rd_en);
    assign ovr     = wr_en & full_q & ~rd_en;
    assign full    = full_q;
    assign rd_data = data_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end else if (rd_en) begin
            full_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
    parameter int W     = 40,
    parameter int DEPTH = 2000,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic         nonempty,
    output logic         full,
    output logic [W-1:0] rd_data,
    output logic         ovr
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          accept;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full     = (count == CW'(DEPTH));
    assign nonempty = (count != '0);
    assign accept   = wr_en & (~full | rd_en);
    assign ovr      = wr_en & full & ~rd_en;
    assign rd_data  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= step(wr_ptr);
            if (rd_en)  rd_ptr <= step(rd_ptr);
            case ({accept, rd_en})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cap_inhibit_seq.sv
module cap_inhibit_seq #(
    parameter int INH_HOLD = 2,
    localparam int HW = (INH_HOLD > 1) ? $clog2(INH_HOLD) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic start,
    output logic inhibit,
    output logic done
);

    logic          busy;
    logic [HW-1:0] cnt;

    assign inhibit = busy;
    assign done    = busy & (cnt == HW'(INH_HOLD - 1));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + HW'(1);
            end
        end
    end

endmodule

// File: rtl/cap_edge_buffer.sv
module cap_edge_buffer
    import cap_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 8,
    parameter int DEPTH     = 2000,
    parameter int INH_HOLD  = 2,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int RD_W = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic [NUM_CH-1:0] rdy_in,
    input  logic [RD_W-1:0]   port_in,
    input  logic              talk_req,
    input  logic              status_req,
    output logic              inhibit,
    output logic              rd_valid,
    output logic [RD_W-1:0]   rd_data,
    output logic              status_valid,
    output logic              status_err,
    output logic              overrun
);

    logic [1:0]      mode_q;
    cap_mode_e       mode;
    logic            flush;
    logic            buffered;
    logic            edge_sel;
    logic            cap_evt;
    logic            pend_q;
    rd_ctl_t         ctl;

    logic            hold_wr, hold_rd, hold_full, hold_ovr;
    logic [RD_W-1:0] hold_data;
    logic            fifo_wr, fifo_rd, fifo_nonempty, fifo_full, fifo_ovr;
    logic [RD_W-1:0] fifo_data;
    logic            seq_done;
    logic            stored;
    logic [RD_W-1:0] head;
    logic            ovr_evt;

    assign mode     = decode_mode(mode_q);
    assign flush    = (mode_sel != mode_q);
    assign buffered = (mode != CM_DIRECT);

    cap_edge_detect #(.NUM_CH(NUM_CH)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .rdy_in   (rdy_in),
        .chan_sel (chan_sel),
        .edge_o   (edge_sel)
    );

    assign cap_evt = edge_sel & ~flush;
    assign hold_wr = cap_evt & (mode == CM_SINGLE);
    assign fifo_wr = cap_evt & (mode == CM_DEEP);

    cap_hold #(.W(RD_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (hold_wr),
        .wr_data (port_in),
        .rd_en   (hold_rd),
        .full    (hold_full),
        .rd_data (hold_data),
        .ovr     (hold_ovr)
    );

    cap_fifo #(.W(RD_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (fifo_wr),
        .wr_data  (port_in),
        .rd_en    (fifo_rd),
        .nonempty (fifo_nonempty),
        .full     (fifo_full),
        .rd_data  (fifo_data),
        .ovr      (fifo_ovr)
    );

    cap_inhibit_seq #(.INH_HOLD(INH_HOLD)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .start   (ctl.start),
        .inhibit (inhibit),
        .done    (seq_done)
    );

    assign stored = ((mode == CM_SINGLE) & hold_full) | ((mode == CM_DEEP) & fifo_nonempty);
    assign head   = (mode == CM_SINGLE) ? hold_data : fifo_data;

    always_comb begin
        logic want;
        want        = (talk_req | pend_q) & buffered & ~flush;
        ctl.serve   = want & stored;
        ctl.pend_nx = want & ~stored;
        ctl.start   = talk_req & ~buffered & ~flush;
    end

    assign hold_rd = ctl.serve & (mode == CM_SINGLE);
    assign fifo_rd = ctl.serve & (mode == CM_DEEP);
    assign ovr_evt = hold_ovr | fifo_ovr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= 2'd0;
            pend_q       <= 1'b0;
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            overrun      <= 1'b0;
            status_valid <= 1'b0;
            status_err   <= 1'b0;
        end else begin
            mode_q       <= mode_sel;
            pend_q       <= ctl.pend_nx;
            rd_valid     <= ctl.serve | (seq_done & ~flush);
            if (ctl.serve) begin
                rd_data <= head;
            end else if (seq_done && !flush) begin
                rd_data <= port_in;
            end
            overrun      <= sticky_next(overrun, status_req, ovr_evt);
            status_valid <= status_req;
            status_err   <= overrun;
        end
    end

endmodule

// File: rtl/cap_edge_buffer_chk.sv
module cap_edge_buffer_chk
    import cap_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_q,
    input logic       inhibit,
    input logic       rd_valid,
    input logic       status_req,
    input logic       status_valid,
    input logic       overrun,
    input logic       ovr_evt,
    input logic       fifo_full,
    input logic       fifo_wr,
    input logic       fifo_pop
);

    a_r12_inhibit_direct_only: assert property (@(posedge clk) disable iff (rst)
        inhibit |-> (decode_mode(mode_q) == CM_DIRECT));

    a_r2_read_follows_inhibit: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && decode_mode($past(mode_q)) == CM_DIRECT) |-> $past(inhibit));

    a_r9_status_reply: assert property (@(posedge clk) disable iff (rst)
        status_req |=> status_valid);

    a_r9_status_clears: assert property (@(posedge clk) disable iff (rst)
        (status_req && !ovr_evt) |=> !overrun);

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !status_req) |=> overrun);

    a_r7_full_drop_flags: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && fifo_wr && !fifo_pop) |=> overrun);

endmodule

bind cap_edge_buffer cap_edge_buffer_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_q       (mode_q),
    .inhibit      (inhibit),
    .rd_valid     (rd_valid),
    .status_req   (status_req),
    .status_valid (status_valid),
    .overrun      (overrun),
    .ovr_evt      (ovr_evt),
    .fifo_full    (fifo_full),
    .fifo_wr      (fifo_wr),
    .fifo_pop     (fifo_rd)
);

// File: tb/test_cap_edge_buffer.sv
module test_cap_edge_buffer;

    localparam int DEPTH = 2000;
    localparam int RD_W  = 40;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      mode_sel = 2'd0;
    logic [0:0]      chan_sel = 1'b0;
    logic [1:0]      rdy_in = 2'b00;
    logic [RD_W-1:0] port_in = '0;
    logic            talk_req = 1'b0;
    logic            status_req = 1'b0;
    logic            inhibit, rd_valid, status_valid, status_err, overrun;
    logic [RD_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    cap_edge_buffer i_cap_edge_buffer (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .chan_sel(chan_sel),
        .rdy_in(rdy_in), .port_in(port_in), .talk_req(talk_req),
        .status_req(status_req), .inhibit(inhibit), .rd_valid(rd_valid),
        .rd_data(rd_data), .status_valid(status_valid),
        .status_err(status_err), .overrun(overrun)
    );

    function automatic logic [RD_W-1:0] pat(input int i);
        logic [31:0] lo;
        lo = 32'(i) * 32'h9E37_79B1 + 32'h0000_1357;
        return {8'(i * 7 + 3), lo};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Toggle a data-ready line with data on the ports; stored after three falling edges
    task automatic capture(input int ch, input logic [RD_W-1:0] d);
        port_in = d;
        rdy_in[ch] = ~rdy_in[ch];
        for (int k = 0; k < 3; k++) begin
            tick();
            check(inhibit == 1'b0, "R12", "inhibit in capture mode", 64'(inhibit), 0);
        end
    endtask

    task automatic talk_expect(input logic [RD_W-1:0] exp, input string req);
        talk_req = 1'b1;
        tick();
        talk_req = 1'b0;
        check(rd_valid == 1'b1, req, "rd_valid", 64'(rd_valid), 1);
        check(rd_data == exp, req, "rd_data", 64'(rd_data), 64'(exp));
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_sel = m;
        tick();
    endtask

    task automatic status_pulse(input logic exp_err, input string req);
        status_req = 1'b1;
        tick();
        status_req = 1'b0;
        check(status_valid == 1'b1, req, "status_valid", 64'(status_valid), 1);
        check(status_err == exp_err, req, "status_err", 64'(status_err), 64'(exp_err));
        check(overrun == 1'b0, req, "overrun cleared", 64'(overrun), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_flag) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        // R1: reset state
        check(inhibit == 0, "R1", "inhibit", 64'(inhibit), 0);
        check(rd_valid == 0, "R1", "rd_valid", 64'(rd_valid), 0);
        check(overrun == 0, "R1", "overrun", 64'(overrun), 0);
        check(status_valid == 0 && status_err == 0, "R1", "status", 64'({status_valid, status_err}), 0);
        tick();

        // R2: direct reads, codes 0 and 3, late port sample, busy request ignored
        for (int i = 0; i < 6; i++) begin
            set_mode((i % 2 == 1) ? 2'd3 : 2'd0);
            port_in = pat(100 + i);
            talk_req = 1'b1;
            tick();
            talk_req = 1'b0;
            check(inhibit == 1 && rd_valid == 0, "R2", "first inhibit cycle", 64'({inhibit, rd_valid}), 2);
            tick();
            check(inhibit == 1 && rd_valid == 0, "R2", "second inhibit cycle", 64'({inhibit, rd_valid}), 2);
            port_in = pat(200 + i);
            talk_req = 1'b1;
            tick();
            talk_req = 1'b0;
            check(inhibit == 0 && rd_valid == 1, "R2", "inhibit release", 64'({inhibit, rd_valid}), 1);
            check(rd_data == pat(200 + i), "R2", "direct sample", 64'(rd_data), 64'(pat(200 + i)));
            tick();
            check(inhibit == 0 && rd_valid == 0, "R2", "busy request ignored", 64'({inhibit, rd_valid}), 0);
        end

        // R4 and R3: single hold, rising edge on selected line
        set_mode(2'd1);
        capture(0, pat(1));
        talk_expect(pat(1), "R4");
        // R8: request with nothing stored waits
        talk_req = 1'b1;
        tick();
        talk_req = 1'b0;
        check(rd_valid == 0, "R8", "no reading while empty", 64'(rd_valid), 0);
        // R3: unselected line does nothing
        port_in = pat(2);
        rdy_in[1] = ~rdy_in[1];
        for (int k = 0; k < 5; k++) begin
            tick();
            check(rd_valid == 0, "R3", "unselected line ignored", 64'(rd_valid), 0);
        end
        // R3/R8: falling edge on selected line, served at the fourth falling edge
        port_in = pat(3);
        rdy_in[0] = ~rdy_in[0];
        for (int k = 1; k <= 5; k++) begin
            tick();
            if (k == 4) begin
                check(rd_valid == 1, "R8", "waiting request served", 64'(rd_valid), 1);
                check(rd_data == pat(3), "R3", "falling edge capture", 64'(rd_data), 64'(pat(3)));
            end else begin
                check(rd_valid == 0, "R8", "one reading per request", 64'(rd_valid), 0);
            end
        end
        capture(0, pat(4));
        talk_expect(pat(4), "R4");

        // R5: overrun in single hold keeps the first reading
        capture(0, pat(5));
        capture(0, pat(6));
        check(overrun == 1, "R5", "overrun set", 64'(overrun), 1);
        for (int k = 0; k < 5; k++) begin
            tick();
            check(overrun == 1, "R10", "flag held", 64'(overrun), 1);
        end
        talk_expect(pat(5), "R5");
        talk_req = 1'b1;
        tick();
        talk_req = 1'b0;
        check(rd_valid == 0, "R5", "dropped reading absent", 64'(rd_valid), 0);
        status_pulse(1'b1, "R9");

        // R6 with chan_sel = 1
        set_mode(2'd2);
        chan_sel = 1'b1;
        capture(1, pat(7));
        capture(0, pat(8));
        talk_expect(pat(7), "R3");
        talk_req = 1'b1;
        tick();
        talk_req = 1'b0;
        check(rd_valid == 0, "R3", "line 0 ignored when line 1 selected", 64'(rd_valid), 0);
        set_mode(2'd0);
        chan_sel = 1'b0;

        // R9: status leaves stored readings and inhibit alone
        set_mode(2'd2);
        capture(0, pat(10));
        capture(0, pat(11));
        status_req = 1'b1;
        tick();
        status_req = 1'b0;
        check(status_valid == 1 && status_err == 0, "R9", "clean status", 64'({status_valid, status_err}), 2);
        check(inhibit == 0 && rd_valid == 0, "R9", "no side effect", 64'({inhibit, rd_valid}), 0);
        talk_expect(pat(10), "R9");
        talk_expect(pat(11), "R9");

        // R6/R7: fill the queue to capacity, then one more
        for (int i = 0; i < DEPTH; i++) capture(0, pat(1000 + i));
        check(overrun == 0, "R6", "full queue no overrun", 64'(overrun), 0);
        capture(0, pat(9999));
        check(overrun == 1, "R7", "2001st reading overrun", 64'(overrun), 1);
        for (int i = 0; i < DEPTH; i++) talk_expect(pat(1000 + i), "R6");
        for (int i = 0; i < 3; i++) capture(0, pat(5000 + i));
        for (int i = 0; i < 3; i++) talk_expect(pat(5000 + i), "R6");
        status_pulse(1'b1, "R10");

        // R11: mode change flushes stored reading and waiting request
        set_mode(2'd1);
        capture(0, pat(20));
        set_mode(2'd2);
        set_mode(2'd1);
        talk_req = 1'b1;
        tick();
        talk_req = 1'b0;
        check(rd_valid == 0, "R11", "held reading flushed", 64'(rd_valid), 0);
        set_mode(2'd0);
        port_in = pat(21);
        rdy_in[0] = ~rdy_in[0];
        repeat (4) tick();
        set_mode(2'd1);
        talk_req = 1'b1;
        tick();
        talk_req = 1'b0;
        check(rd_valid == 0, "R11", "direct mode stores nothing", 64'(rd_valid), 0);
        port_in = pat(22);
        rdy_in[0] = ~rdy_in[0];
        repeat (4) tick();
        check(rd_valid == 1 && rd_data == pat(22), "R11", "later capture served", 64'(rd_data), 64'(pat(22)));
        tick();

        finish_run();
    end

endmodule